// File: doc/BRIEF.md
# TLB Translation Token Tracker

This block is a small set-associative translation cache that also keeps coherence tokens, so that translation coherence can be checked while the chip runs. Every translation in the system owns a fixed pool of `TOKENS` tokens. The pool is sized to be at least the number of translation caches that could hold a copy, for example two per core when each core has separate instruction and data caches. Each cached entry stores its virtual-to-physical mapping, the physical address of the page table entry (PTE) that defines it, and the number of tokens it currently holds. The node that owns a translation's tokens is the top `NODE_W` bits of that PTE address.

Tokens leave the block as messages that carry the PTE address, a destination node and a count. An entry replaced for capacity returns its tokens to the owning node. An entry removed by an invalidation sends them to the node that asked for it. A full flush sends the tokens of every valid entry to the node that started the flush. Page walks, the page table itself and the message network stay outside the block. The block sees them only as request inputs and a valid/ready output.

Two checks run beside normal operation and add no latency. A lookup that hits an entry holding no tokens is a coherence error. A local remap that finishes without the complete token pool is also an error. Both errors are kept as sticky flags.

Top module: `tlbtok_tracker`

## Requirements
- R1: A lookup returns hit and the stored physical page number combinationally, in the same cycle. A lookup of an absent page reports no hit.
- R2: A fill into a set that has a free way uses the lowest-numbered free way. It stores the token count delivered with the fill (normally one) and sends no message.
- R3: A fill into a full set replaces the victim chosen by R4. It sends one message with the victim's PTE address, the victim's token count, and destination equal to the top `NODE_W` bits of that PTE address.
- R4: The victim is chosen by a binary-tree pseudo-LRU per set. Both fills and lookup hits count as uses, so after uses of ways 0,1,2,3 and then 0, way 2 is the victim.
- R5: An invalidation that hits removes the entry and sends its PTE address and token count to the requesting node. An invalidation that misses sends nothing.
- R6: A flush sends one message to the initiator for every valid entry, in increasing flat index order (set-major, way-minor), and leaves every entry invalid.
- R7: A lookup that hits an entry with zero tokens sets `err_kind[0]` on the next clock edge. The lookup result itself is unaffected.
- R8: A remap completion sets `err_kind[1]` on the next edge unless `rm_held` plus the tokens of a matching entry equals `TOKENS` exactly.
- R9: Error bits are sticky until reset. `err_flag` is the OR of `err_kind`.
- R10: A pending message keeps its fields stable until it is accepted. `op_ready` is low while a message is pending or a flush is running, and fill, invalidation and flush requests made while `op_ready` is low have no effect.
- R11: After reset all entries are invalid, no message is pending, no error is set and `op_ready` is high.
- R12: When requests arrive together, a flush is taken before an invalidation, and an invalidation before a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hit entry |
| op_ready | output | 1 | Fill, invalidation and flush are accepted |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | VPN_W | Virtual page to fill |
| fill_ppn | input | PPN_W | Physical page to fill |
| fill_pte | input | PTE_AW | PTE physical address of the translation |
| fill_tok | input | CNT_W | Tokens delivered with the fill |
| inv_valid | input | 1 | Invalidation request |
| inv_vpn | input | VPN_W | Page to invalidate |
| inv_src | input | NODE_W | Requesting node |
| flush_valid | input | 1 | Flush request |
| flush_src | input | NODE_W | Flush initiator node |
| rm_valid | input | 1 | Local remap completion |
| rm_vpn | input | VPN_W | Page being remapped |
| rm_held | input | CNT_W | Tokens held by the core outside this cache |
| msg_valid | output | 1 | Token message pending |
| msg_ready | input | 1 | Token message accepted |
| msg_pte | output | PTE_AW | PTE address carried by the message |
| msg_dest | output | NODE_W | Destination node |
| msg_count | output | CNT_W | Number of tokens carried |
| err_flag | output | 1 | Any coherence error seen |
| err_kind | output | 2 | Bit 0: access without a token; bit 1: remap without the full pool |

## Verification
The checker watches the message handshake, the gating of `op_ready`, and the two error rules on every cycle: a zero-token hit or an unbalanced remap must raise its bit on the next edge, and raised bits never clear. The bench's scenarios are what show which way a fill or eviction picks, which node gets the tokens, the order of flush messages, and the fact that a request made while busy leaves no entry behind. None of these can be seen from a single cycle.

// File: rtl/tlbtok_pkg.sv
package tlbtok_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } fsm_t;

   localparam int ERR_W      = 2;
   localparam int ERR_ACCESS = 0;
   localparam int ERR_REMAP  = 1;
endpackage

// File: rtl/tlbtok_plru.sv
module tlbtok_plru #(
   parameter int SETS = 32,
   parameter int WAYS = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] q_set,
   output logic [WAY_W-1:0] q_way
);
   localparam int NODES = WAYS - 1;
   localparam int LVL   = WAY_W;

   logic [NODES-1:0] tree [SETS];

   // walk from the root following the stored direction bits
   function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] t);
      int n;
      n = 0;
      for (int l = 0; l < LVL; l++) n = 2 * n + 1 + int'(t[n]);
      return WAY_W'(n - NODES);
   endfunction

   // make every node on the path point away from the used way
   function automatic logic [NODES-1:0] upd(input logic [NODES-1:0] t,
                                            input logic [WAY_W-1:0] w);
      logic [NODES-1:0] r;
      int n, p;
      r = t;
      n = int'(w) + NODES;
      for (int l = 0; l < LVL; l++) begin
         p    = (n - 1) / 2;
         r[p] = (n == 2 * p + 1);
         n    = p;
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree[s] <= '0;
      end else if (touch_en) begin
         tree[touch_set] <= upd(tree[touch_set], touch_way);
      end
   end

   assign q_way = pick(tree[q_set]);
endmodule

// File: rtl/tlbtok_array.sv
module tlbtok_array #(
   parameter int SETS   = 32,
   parameter int WAYS   = 4,
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int PTE_AW = 32,
   parameter int CNT_W  = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = SET_W + WAY_W
)(
   input  logic              clk,
   input  logic              rst_n,
   // port A: lookup
   input  logic [VPN_W-1:0]  a_vpn,
   output logic              a_hit,
   output logic [WAY_W-1:0]  a_way,
   output logic [PPN_W-1:0]  a_ppn,
   output logic [CNT_W-1:0]  a_tok,
   // port B: fill / invalidation
   input  logic [VPN_W-1:0]  b_vpn,
   output logic              b_hit,
   output logic [WAY_W-1:0]  b_way,
   output logic [WAYS-1:0]   b_free,
   // port C: remap check
   input  logic [VPN_W-1:0]  c_vpn,
   output logic              c_hit,
   output logic [CNT_W-1:0]  c_tok,
   // flat read port
   input  logic [IDX_W-1:0]  r_idx,
   output logic              r_valid,
   output logic [PTE_AW-1:0] r_pte,
   output logic [CNT_W-1:0]  r_tok,
   // write port
   input  logic              w_en,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic              w_valid,
   input  logic [VPN_W-1:0]  w_vpn,
   input  logic [PPN_W-1:0]  w_ppn,
   input  logic [PTE_AW-1:0] w_pte,
   input  logic [CNT_W-1:0]  w_tok
);
   localparam int DEPTH = SETS * WAYS;
   localparam int TAG_W = VPN_W - SET_W;
   localparam int NP    = 3;

   logic [DEPTH-1:0]  v;
   logic [TAG_W-1:0]  tag [DEPTH];
   logic [PPN_W-1:0]  ppn [DEPTH];
   logic [PTE_AW-1:0] pte [DEPTH];
   logic [CNT_W-1:0]  tok [DEPTH];

   logic [NP-1:0][VPN_W-1:0] pv;
   logic [NP-1:0][WAYS-1:0]  hv;

   assign pv[0] = a_vpn;
   assign pv[1] = b_vpn;
   assign pv[2] = c_vpn;

   for (genvar gp = 0; gp < NP; gp++) begin : g_port
      for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
         assign hv[gp][gw] = v[{pv[gp][SET_W-1:0], WAY_W'(gw)}] &&
                             (tag[{pv[gp][SET_W-1:0], WAY_W'(gw)}] == pv[gp][VPN_W-1:SET_W]);
      end
   end

   for (genvar gw = 0; gw < WAYS; gw++) begin : g_free
      assign b_free[gw] = !v[{b_vpn[SET_W-1:0], WAY_W'(gw)}];
   end

   always_comb begin
      a_way = '0;
      a_ppn = '0;
      a_tok = '0;
      b_way = '0;
      c_tok = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hv[0][w]) begin
            a_way = WAY_W'(w);
            a_ppn = ppn[{a_vpn[SET_W-1:0], WAY_W'(w)}];
            a_tok = tok[{a_vpn[SET_W-1:0], WAY_W'(w)}];
         end
         if (hv[1][w]) b_way = WAY_W'(w);
         if (hv[2][w]) c_tok = tok[{c_vpn[SET_W-1:0], WAY_W'(w)}];
      end
   end

   assign a_hit   = |hv[0];
   assign b_hit   = |hv[1];
   assign c_hit   = |hv[2];
   assign r_valid = v[r_idx];
   assign r_pte   = pte[r_idx];
   assign r_tok   = tok[r_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v <= '0;
      else if (w_en) v[w_idx] <= w_valid;
   end

   always_ff @(posedge clk) begin
      if (w_en && w_valid) begin
         tag[w_idx] <= w_vpn[VPN_W-1:SET_W];
         ppn[w_idx] <= w_ppn;
         pte[w_idx] <= w_pte;
         tok[w_idx] <= w_tok;
      end
   end
endmodule

// File: rtl/tlbtok_msgq.sv
module tlbtok_msgq #(
   parameter int PTE_AW = 32,
   parameter int NODE_W = 4,
   parameter int CNT_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [PTE_AW-1:0] ld_pte,
   input  logic [NODE_W-1:0] ld_dest,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [PTE_AW-1:0] out_pte,
   output logic [NODE_W-1:0] out_dest,
   output logic [CNT_W-1:0]  out_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pte   <= '0;
         out_dest  <= '0;
         out_cnt   <= '0;
      end else if (ld) begin
         out_valid <= 1'b1;
         out_pte   <= ld_pte;
         out_dest  <= ld_dest;
         out_cnt   <= ld_cnt;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/tlbtok_tracker.sv
module tlbtok_tracker import tlbtok_pkg::*; #(
   parameter int SETS          = 32,
   parameter int WAYS          = 4,
   parameter int VPN_W         = 20,
   parameter int PPN_W         = 20,
   parameter int PTE_AW        = 32,
   parameter int NODE_W        = 4,
   parameter int CORES         = 4,
   parameter int TLBS_PER_CORE = 2,
   parameter int TOKENS        = CORES * TLBS_PER_CORE,
   localparam int CNT_W        = $clog2(TOKENS + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic              op_ready,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PTE_AW-1:0] fill_pte,
   input  logic [CNT_W-1:0]  fill_tok,
   input  logic              inv_valid,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [NODE_W-1:0] inv_src,
   input  logic              flush_valid,
   input  logic [NODE_W-1:0] flush_src,
   input  logic              rm_valid,
   input  logic [VPN_W-1:0]  rm_vpn,
   input  logic [CNT_W-1:0]  rm_held,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [PTE_AW-1:0] msg_pte,
   output logic [NODE_W-1:0] msg_dest,
   output logic [CNT_W-1:0]  msg_count,
   output logic              err_flag,
   output logic [ERR_W-1:0]  err_kind
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int IDX_W = SET_W + WAY_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS * WAYS - 1);

   // elaboration-time parameter checks
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (VPN_W <= SET_W) begin : g_bad_vpn
      $error("VPN_W must exceed the set index width");
   end
   if (NODE_W > PTE_AW) begin : g_bad_node
      $error("NODE_W must not exceed PTE_AW");
   end
   if (TOKENS < CORES * TLBS_PER_CORE) begin : g_bad_tokens
      $error("TOKENS must cover every translation cache in the system");
   end

   fsm_t              state;
   logic [IDX_W-1:0]  scan_idx;
   logic [NODE_W-1:0] fl_src;

   logic              a_hit, b_hit, c_hit, r_valid;
   logic [WAY_W-1:0]  a_way, b_way, plru_way, free_way, vic_way;
   logic [PPN_W-1:0]  a_ppn;
   logic [CNT_W-1:0]  a_tok, c_tok, r_tok;
   logic [WAYS-1:0]   b_free;
   logic [PTE_AW-1:0] r_pte;
   logic [IDX_W-1:0]  r_idx;
   logic [VPN_W-1:0]  ctl_vpn;
   logic [SET_W-1:0]  ctl_set;
   logic              has_free, evict;
   logic              do_flush, do_inv, do_fill, scan_step;
   logic              w_en, w_valid;
   logic              ld;
   logic [NODE_W-1:0] ld_dest;
   logic [CNT_W:0]    rm_total;
   logic              touch_en;
   logic [SET_W-1:0]  touch_set;
   logic [WAY_W-1:0]  touch_way;
   logic [ERR_W-1:0]  err_q;

   // request arbitration: flush, then invalidation, then fill
   assign op_ready  = (state == ST_IDLE) && !msg_valid;
   assign do_flush  = op_ready && flush_valid;
   assign do_inv    = op_ready && inv_valid && !flush_valid;
   assign do_fill   = op_ready && fill_valid && !flush_valid && !inv_valid;
   assign scan_step = (state == ST_SCAN) && !msg_valid;

   assign ctl_vpn = inv_valid ? inv_vpn : fill_vpn;
   assign ctl_set = ctl_vpn[SET_W-1:0];

   tlbtok_array #(
      .SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .PTE_AW(PTE_AW), .CNT_W(CNT_W)
   ) u_arr (
      .clk(clk), .rst_n(rst_n),
      .a_vpn(lk_vpn), .a_hit(a_hit), .a_way(a_way), .a_ppn(a_ppn), .a_tok(a_tok),
      .b_vpn(ctl_vpn), .b_hit(b_hit), .b_way(b_way), .b_free(b_free),
      .c_vpn(rm_vpn), .c_hit(c_hit), .c_tok(c_tok),
      .r_idx(r_idx), .r_valid(r_valid), .r_pte(r_pte), .r_tok(r_tok),
      .w_en(w_en), .w_idx(r_idx), .w_valid(w_valid),
      .w_vpn(fill_vpn), .w_ppn(fill_ppn), .w_pte(fill_pte), .w_tok(fill_tok)
   );

   tlbtok_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk(clk), .rst_n(rst_n),
      .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
      .q_set(ctl_set), .q_way(plru_way)
   );

   // lowest-numbered free way of the fill set
   always_comb begin
      free_way = '0;
      has_free = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (b_free[w] && !has_free) begin
            free_way = WAY_W'(w);
            has_free = 1'b1;
         end
      end
   end

   assign vic_way = b_hit ? b_way : (has_free ? free_way : plru_way);
   assign evict   = !b_hit && !has_free;
   assign r_idx   = (state == ST_SCAN) ? scan_idx
                                       : {ctl_set, (inv_valid ? b_way : vic_way)};

   // single write port: scan clear, invalidation clear, fill
   always_comb begin
      w_en    = 1'b0;
      w_valid = 1'b0;
      if (scan_step) begin
         w_en = 1'b1;
      end else if (do_inv && b_hit) begin
         w_en = 1'b1;
      end else if (do_fill) begin
         w_en    = 1'b1;
         w_valid = 1'b1;
      end
   end

   // outgoing token message selection
   assign ld      = (scan_step && r_valid) || (do_inv && b_hit) || (do_fill && evict);
   assign ld_dest = scan_step ? fl_src :
                    (do_inv ? inv_src : r_pte[PTE_AW-1 -: NODE_W]);

   tlbtok_msgq #(.PTE_AW(PTE_AW), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_msg (
      .clk(clk), .rst_n(rst_n),
      .ld(ld), .ld_pte(r_pte), .ld_dest(ld_dest), .ld_cnt(r_tok),
      .out_ready(msg_ready), .out_valid(msg_valid),
      .out_pte(msg_pte), .out_dest(msg_dest), .out_cnt(msg_count)
   );

   // flush scanner
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         scan_idx <= '0;
         fl_src   <= '0;
      end else if (state == ST_IDLE) begin
         if (do_flush) begin
            state    <= ST_SCAN;
            scan_idx <= '0;
            fl_src   <= flush_src;
         end
      end else if (scan_step) begin
         scan_idx <= scan_idx + 1'b1;
         if (scan_idx == LAST_IDX) state <= ST_IDLE;
      end
   end

   // replacement state: a fill takes the update slot over a lookup
   assign touch_en  = do_fill || (lk_valid && a_hit);
   assign touch_set = do_fill ? ctl_set : lk_vpn[SET_W-1:0];
   assign touch_way = do_fill ? vic_way : a_way;

   // token-ownership checks
   assign rm_total = (CNT_W + 1)'(rm_held) + (c_hit ? (CNT_W + 1)'(c_tok) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
      end else begin
         if (lk_valid && a_hit && (a_tok == '0)) err_q[ERR_ACCESS] <= 1'b1;
         if (rm_valid && (rm_total != (CNT_W + 1)'(TOKENS))) err_q[ERR_REMAP] <= 1'b1;
      end
   end

   assign lk_hit   = lk_valid && a_hit;
   assign lk_ppn   = a_ppn;
   assign err_kind = err_q;
   assign err_flag = |err_q;
endmodule

// File: rtl/tlbtok_chk.sv
module tlbtok_chk #(
   parameter int PTE_AW = 32,
   parameter int NODE_W = 4,
   parameter int CNT_W  = 4,
   parameter int TOKENS = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [PTE_AW-1:0] msg_pte,
   input logic [NODE_W-1:0] msg_dest,
   input logic [CNT_W-1:0]  msg_count,
   input logic              op_ready,
   input logic [1:0]        err_kind,
   input logic              lk_valid,
   input logic              lk_hit,
   input logic [CNT_W-1:0]  lk_tok,
   input logic              rm_valid,
   input logic [CNT_W:0]    rm_total
);
   p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_pte) &&
                                  $stable(msg_dest) && $stable(msg_count));

   p_busy_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !op_ready);

   p_access_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_hit && (lk_tok == '0) |=> err_kind[0]);

   p_remap_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rm_valid && (rm_total != (CNT_W + 1)'(TOKENS)) |=> err_kind[1]);

   p_sticky_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_kind[0] |=> err_kind[0]);

   p_sticky_remap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_kind[1] |=> err_kind[1]);
endmodule

bind tlbtok_tracker tlbtok_chk #(
   .PTE_AW(PTE_AW), .NODE_W(NODE_W), .CNT_W(CNT_W), .TOKENS(TOKENS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pte(msg_pte),
   .msg_dest(msg_dest), .msg_count(msg_count), .op_ready(op_ready),
   .err_kind(err_kind), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_tok(a_tok),
   .rm_valid(rm_valid), .rm_total(rm_total)
);

// File: tb/sim_tlbtok_tracker.sv
`timescale 1ns/1ps
module sim_tlbtok_tracker;
   localparam int VPN_W = 20, PPN_W = 20, PTE_AW = 32, NODE_W = 4, CNT_W = 4;
   localparam int TOK = 8;
   localparam realtime CLK_P = 5.0;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 0;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic              lk_hit;
   logic [PPN_W-1:0]  lk_ppn;
   logic              op_ready;
   logic              fill_valid = 0;
   logic [VPN_W-1:0]  fill_vpn = '0;
   logic [PPN_W-1:0]  fill_ppn = '0;
   logic [PTE_AW-1:0] fill_pte = '0;
   logic [CNT_W-1:0]  fill_tok = '0;
   logic              inv_valid = 0;
   logic [VPN_W-1:0]  inv_vpn = '0;
   logic [NODE_W-1:0] inv_src = '0;
   logic              flush_valid = 0;
   logic [NODE_W-1:0] flush_src = '0;
   logic              rm_valid = 0;
   logic [VPN_W-1:0]  rm_vpn = '0;
   logic [CNT_W-1:0]  rm_held = '0;
   logic              msg_valid;
   logic              msg_ready = 0;
   logic [PTE_AW-1:0] msg_pte;
   logic [NODE_W-1:0] msg_dest;
   logic [CNT_W-1:0]  msg_count;
   logic              err_flag;
   logic [1:0]        err_kind;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_P / 2) clk = ~clk;

   tlbtok_tracker u0 (.*);

   function automatic logic [PTE_AW-1:0] pte_of(input logic [VPN_W-1:0] v);
      return {v[8:5] + 4'd1, 8'h00, v};
   endfunction
   function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
      return v ^ 20'hABCDE;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic op_fill(input logic [VPN_W-1:0] v, input logic [CNT_W-1:0] t);
      while (!op_ready) @(negedge clk);
      fill_valid = 1; fill_vpn = v; fill_ppn = ppn_of(v); fill_pte = pte_of(v); fill_tok = t;
      @(negedge clk);
      fill_valid = 0;
   endtask

   task automatic op_inv(input logic [VPN_W-1:0] v, input logic [NODE_W-1:0] s);
      while (!op_ready) @(negedge clk);
      inv_valid = 1; inv_vpn = v; inv_src = s;
      @(negedge clk);
      inv_valid = 0;
   endtask

   task automatic look(input logic [VPN_W-1:0] v, input bit hit, input string req);
      lk_valid = 1; lk_vpn = v;
      #1;
      check(req, 64'(lk_hit), 64'(hit));
      if (hit) check(req, 64'(lk_ppn), 64'(ppn_of(v)));
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic expect_msg(input logic [PTE_AW-1:0] p, input logic [NODE_W-1:0] d,
                             input logic [CNT_W-1:0] c, input string req);
      for (int w = 0; w < 400 && !msg_valid; w++) @(negedge clk);
      check(req, 64'(msg_valid), 64'd1);
      check(req, 64'(msg_pte), 64'(p));
      check(req, 64'(msg_dest), 64'(d));
      check(req, 64'(msg_count), 64'(c));
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
   endtask

   task automatic remap(input logic [VPN_W-1:0] v, input logic [CNT_W-1:0] h);
      rm_valid = 1; rm_vpn = v; rm_held = h;
      @(negedge clk);
      rm_valid = 0;
   endtask

   // R11, R1: state straight after reset
   task automatic t_reset();
      do_reset();
      check("R11 op_ready", 64'(op_ready), 64'd1);
      check("R11 msg_valid", 64'(msg_valid), 64'd0);
      check("R11 err_kind", 64'(err_kind), 64'd0);
      check("R11 err_flag", 64'(err_flag), 64'd0);
      look(20'h00000, 0, "R11 empty lookup");
   endtask

   // R2, R1: fills into free ways of set 0, no messages
   task automatic t_fill_free();
      for (int i = 0; i < 4; i++) begin
         op_fill(20'(i * 32), 4'd1);
         check("R2 no msg on free fill", 64'(msg_valid), 64'd0);
         look(20'(i * 32), 1, "R1 hit after fill");
      end
      look(20'h00100, 0, "R1 miss on absent page");
   endtask

   // R4, R3: lookup of way 0 moves the victim to way 2 (page 0x40)
   task automatic t_evict();
      look(20'h00000, 1, "R4 touch way0");
      op_fill(20'h00080, 4'd1);
      expect_msg(pte_of(20'h00040), 4'd3, 4'd1, "R3 R4 eviction to home node");
      look(20'h00040, 0, "R4 victim gone");
      look(20'h00080, 1, "R3 new entry present");
      look(20'h00000, 1, "R4 recently used kept");
   endtask

   // R5: invalidation hit and miss
   task automatic t_inv();
      op_inv(20'h00020, 4'd5);
      expect_msg(pte_of(20'h00020), 4'd5, 4'd1, "R5 token to requester");
      look(20'h00020, 0, "R5 entry removed");
      op_inv(20'h00020, 4'd5);
      check("R5 miss sends nothing", 64'(msg_valid), 64'd0);
   endtask

   // R7, R8, R9: error detection
   task automatic t_errors();
      op_fill(20'h00003, 4'd0);
      check("R7 no error before access", 64'(err_kind), 64'd0);
      look(20'h00003, 1, "R7 zero-token hit still returns ppn");
      check("R7 access error", 64'(err_kind), 64'd1);
      check("R9 flag", 64'(err_flag), 64'd1);
      remap(20'h00000, 4'd7);
      check("R8 complete pool no error", 64'(err_kind), 64'd1);
      remap(20'h01777, 4'd8);
      check("R8 pool held outside cache", 64'(err_kind), 64'd1);
      remap(20'h00000, 4'd5);
      check("R8 incomplete pool", 64'(err_kind), 64'd3);
      repeat (4) @(negedge clk);
      check("R9 sticky", 64'(err_kind), 64'd3);
   endtask

   // R10: stalled message and ignored request
   task automatic t_stall();
      logic [PTE_AW-1:0] p;
      op_inv(20'h00060, 4'd9);
      p = msg_pte;
      for (int i = 0; i < 3; i++) begin
         check("R10 msg held", 64'(msg_valid), 64'd1);
         check("R10 fields stable", 64'(msg_pte), 64'(p));
         check("R10 op_ready low", 64'(op_ready), 64'd0);
         if (i == 0) begin
            fill_valid = 1; fill_vpn = 20'h00005; fill_ppn = ppn_of(20'h00005);
            fill_pte = pte_of(20'h00005); fill_tok = 4'd1;
         end
         @(negedge clk);
         fill_valid = 0;
      end
      expect_msg(pte_of(20'h00060), 4'd9, 4'd1, "R10 released message");
      look(20'h00005, 0, "R10 busy fill ignored");
   endtask

   // R12: flush wins over a simultaneous invalidation and fill
   task automatic t_priority();
      while (!op_ready) @(negedge clk);
      flush_valid = 1; flush_src = 4'd7;
      inv_valid = 1; inv_vpn = 20'h00000; inv_src = 4'd2;
      fill_valid = 1; fill_vpn = 20'h00009; fill_ppn = ppn_of(20'h00009);
      fill_pte = pte_of(20'h00009); fill_tok = 4'd1;
      @(negedge clk);
      flush_valid = 0; inv_valid = 0; fill_valid = 0;
      expect_msg(pte_of(20'h00000), 4'd7, 4'd1, "R12 flush taken first");
      look(20'h00009, 0, "R12 fill dropped");
   endtask

   // R6, R11: flush order after a fresh reset
   task automatic t_flush();
      do_reset();
      check("R11 errors cleared", 64'(err_kind), 64'd0);
      op_fill(20'h00201, 4'd1);
      op_fill(20'h00022, 4'd2);
      op_fill(20'h00101, 4'd1);
      while (!op_ready) @(negedge clk);
      flush_valid = 1; flush_src = 4'd3;
      @(negedge clk);
      flush_valid = 0;
      expect_msg(pte_of(20'h00201), 4'd3, 4'd1, "R6 first in index order");
      expect_msg(pte_of(20'h00101), 4'd3, 4'd1, "R6 second in index order");
      expect_msg(pte_of(20'h00022), 4'd3, 4'd2, "R6 third in index order");
      for (int w = 0; w < 400 && !op_ready; w++) @(negedge clk);
      check("R6 scan ends", 64'(op_ready), 64'd1);
      check("R6 no extra message", 64'(msg_valid), 64'd0);
      look(20'h00201, 0, "R6 flushed");
      look(20'h00022, 0, "R6 flushed");
   endtask

   initial begin
      t_reset();
      t_fill_free();
      t_evict();
      t_inv();
      t_errors();
      t_stall();
      t_priority();
      t_flush();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule